// File: doc/BRIEF.md
# Shared Cascaded Tick Timer Bank

This block produces a set of periodic one-cycle ticks from a single clock. Each timer has a fixed period counted in clock cycles and drives its own tick line. When a timer's period is an exact multiple of a shorter period in the same bank, its counter does not count raw clocks. It counts the wrap events of that shorter timer. Its counter then only needs enough bits to reach the ratio of the two periods, not the full period.

All counters share one enable input and one synchronous reset input. An extra channel takes its period from an input bus at run time rather than from a parameter. A new value on that bus is picked up only when the channel's count wraps, so a period that is in progress is never cut short or stretched.

A typical use is to derive slow housekeeping strobes, such as debounce, scan or timeout ticks, from one system clock. The bank shares one counter chain among all of them.

Top module: `tick_bank`

## Requirements
- R1: A timer whose period P has no divisor in the bank counts raw clocks. With reset released and enable held high, its tick output is high after the P-th enabled rising edge, and again after every further P enabled edges.
- R2: A timer's parent is the largest other period in the bank that lies in [2, P) and divides P exactly. The child counter advances only on its parent's wrap. The child's tick is high only in cycles where the parent's tick is high. Each child tick still falls on every P enabled cycles.
- R3: While enable is low, every counter keeps its value and every tick output, including the dynamic one, keeps the value it had, even if that value is high.
- R4: While reset is high, every counter is cleared and every tick output reads 0 on the next cycle, whatever the enable input is.
- R5: The dynamic channel loads its period from the input bus during reset and again at every wrap. A bus change between wraps only affects the spacing after the next wrap.
- R6: A dynamic period of 0 or 1 makes the dynamic tick high after every enabled cycle.
- R7: For any static timer with period of at least 2, a tick that is high in an enabled cycle is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all counters |
| rst | input | 1 | Synchronous active-high reset of the whole bank |
| en | input | 1 | Common count enable; low freezes counters and ticks |
| dyn_period | input | DYN_W | Period for the dynamic channel, sampled at reset and at each wrap |
| ticks | output | N_TIMERS | One registered tick per static timer, bit i for period entry i |
| dyn_tick | output | 1 | Registered tick of the dynamic channel |

## Verification
Two events can land in the same cycle. One is a tick being raised. The other is the enable dropping, or a new dynamic period arriving. The bench waits until the shortest timer's tick is high and then lowers the enable on that very cycle. It holds the enable low for several cycles and judges that the high tick and the counter positions survive the pause. It also changes the dynamic period mid-count and on a wrap cycle. The tick spacing is then compared every clock against a behavioural model that counts enabled cycles modulo each period.

// File: rtl/tick_bank_pkg.sv
package tick_bank_pkg;

    localparam int MAX_TIMERS = 8;

    typedef int unsigned period_list_t [MAX_TIMERS];

    // Index of the largest other period in [2, own) that divides own exactly; -1 if none.
    function automatic int parent_of(period_list_t p, int n, int idx);
        int best;
        int best_p;
        best   = -1;
        best_p = 0;
        for (int j = 0; j < n; j++) begin
            if (j != idx && p[j] >= 2 && p[j] < p[idx] && (p[idx] % p[j]) == 0
                && p[j] > best_p) begin
                best   = j;
                best_p = int'(p[j]);
            end
        end
        return best;
    endfunction

    // Maximum counter value for entry idx.
    function automatic int limit_of(period_list_t p, int n, int idx);
        int par;
        int own;
        own = (p[idx] == 0) ? 1 : int'(p[idx]);
        par = parent_of(p, n, idx);
        if (par < 0)
            return own - 1;
        return own / int'(p[par]) - 1;
    endfunction

    function automatic int width_for(int maxval);
        return (maxval < 1) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         wrap,
    output logic         tick
);
    logic [W-1:0] cnt_q;
    logic         adv;

    assign adv  = en & step;
    assign wrap = adv & (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (en) begin
            tick <= wrap;
            if (adv)
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tick_dyn_channel.sv
module tick_dyn_channel #(
    parameter int DYN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DYN_W-1:0] period_in,
    output logic             tick
);
    logic [DYN_W-1:0] per_q;
    logic [DYN_W-1:0] lim;
    logic             wrap;

    assign lim = (per_q <= DYN_W'(1)) ? '0 : per_q - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || wrap)
            per_q <= period_in;
    end

    tick_counter #(.W(DYN_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .step  (1'b1),
        .limit (lim),
        .wrap  (wrap),
        .tick  (tick)
    );
endmodule

// File: rtl/tick_bank.sv
module tick_bank
    import tick_bank_pkg::*;
#(
    parameter int           N_TIMERS = 4,
    parameter period_list_t PERIODS  = '{3, 6, 12, 5, 0, 0, 0, 0},
    parameter int           DYN_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [DYN_W-1:0]    dyn_period,
    output logic [N_TIMERS-1:0] ticks,
    output logic                dyn_tick
);
    logic wrap_a [N_TIMERS];

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
        localparam int PAR = parent_of(PERIODS, N_TIMERS, g);
        localparam int LIM = limit_of(PERIODS, N_TIMERS, g);
        localparam int W   = width_for(LIM);
        localparam logic [W-1:0] LIM_V = W'(LIM);

        logic step;
        logic wrap_s;
        logic tick_s;

        if (PAR < 0) begin : g_raw
            assign step = 1'b1;
        end else begin : g_child
            assign step = wrap_a[PAR];
        end

        tick_counter #(.W(W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .en    (en),
            .step  (step),
            .limit (LIM_V),
            .wrap  (wrap_s),
            .tick  (tick_s)
        );

        assign wrap_a[g] = wrap_s;
        assign ticks[g]  = tick_s;
    end

    tick_dyn_channel #(.DYN_W(DYN_W)) u_dyn (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .period_in (dyn_period),
        .tick      (dyn_tick)
    );
endmodule

// File: rtl/tick_bank_chk.sv
module tick_bank_chk
    import tick_bank_pkg::*;
#(
    parameter int           N_TIMERS = 4,
    parameter period_list_t PERIODS  = '{3, 6, 12, 5, 0, 0, 0, 0},
    parameter int           DYN_W    = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic [DYN_W-1:0]    dyn_period,
    input logic [N_TIMERS-1:0] ticks,
    input logic                dyn_tick
);
    p_reset_clears_r4: assert property (@(posedge clk)
        rst |=> (ticks == '0 && !dyn_tick));

    p_pause_holds_r3: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(ticks) && $stable(dyn_tick)));

    p_small_period_every_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        (en && dyn_tick && dyn_period <= DYN_W'(1)) |=> dyn_tick);

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_chk
        localparam int PAR = parent_of(PERIODS, N_TIMERS, g);
        if (PERIODS[g] >= 2) begin : g_narrow
            p_single_cycle_tick_r7: assert property (@(posedge clk) disable iff (rst)
                (en && ticks[g]) |=> !ticks[g]);
        end
        if (PAR >= 0) begin : g_nested
            p_child_within_parent_r2: assert property (@(posedge clk) disable iff (rst)
                ticks[g] |-> ticks[PAR]);
        end
    end
endmodule

bind tick_bank tick_bank_chk #(
    .N_TIMERS (N_TIMERS),
    .PERIODS  (PERIODS),
    .DYN_W    (DYN_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .dyn_period (dyn_period),
    .ticks      (ticks),
    .dyn_tick   (dyn_tick)
);

// File: tb/tick_bank_tb.sv
module tick_bank_tb;
    import tick_bank_pkg::*;

    localparam int           CLK_PERIOD = 10;
    localparam int           N          = 4;
    localparam int           DW         = 8;
    localparam period_list_t PER        = '{3, 6, 12, 5, 0, 0, 0, 0};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [DW-1:0] dyn_period = 8'd4;
    logic [N-1:0]  ticks;
    logic          dyn_tick;

    int checks = 0;
    int errors = 0;
    string phase = "R4";

    // behavioural reference
    int   m_n [N];
    logic m_tick [N];
    int   m_dc;
    int   m_dper;
    logic m_dtick;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_bank #(.N_TIMERS(N), .PERIODS(PER), .DYN_W(DW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .dyn_period (dyn_period),
        .ticks      (ticks),
        .dyn_tick   (dyn_tick)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_n[i]    = 0;
                m_tick[i] = 1'b0;
            end
            m_dc    = 0;
            m_dper  = int'(dyn_period);
            m_dtick = 1'b0;
        end else if (en) begin
            for (int i = 0; i < N; i++) begin
                m_n[i]    = m_n[i] + 1;
                m_tick[i] = ((m_n[i] % int'(PER[i])) == 0);
            end
            if (m_dc + 1 >= m_dper) begin
                m_dtick = 1'b1;
                m_dc    = 0;
                m_dper  = int'(dyn_period);
            end else begin
                m_dtick = 1'b0;
                m_dc    = m_dc + 1;
            end
        end
    end

    task automatic compare();
        for (int i = 0; i < N; i++) begin
            checks++;
            if (ticks[i] !== m_tick[i]) begin
                errors++;
                $display("FAIL %s timer %0d: actual %b expected %b at %0t",
                         phase, i, ticks[i], m_tick[i], $time);
            end
        end
        checks++;
        if (dyn_tick !== m_dtick) begin
            errors++;
            $display("FAIL %s dynamic: actual %b expected %b at %0t",
                     phase, dyn_tick, m_dtick, $time);
        end
    endtask

    // one clock: drive after falling edge, compare at next falling edge
    task automatic cycle(input logic r, input logic e);
        rst = r;
        en  = e;
        @(negedge clk);
        compare();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R4: reset state
        phase = "R4 reset state";
        for (int k = 0; k < 3; k++) cycle(1'b1, 1'b1);

        // R1, R2, R7, R5: free running with dynamic period 4
        phase = "R1/R2/R7 free run";
        for (int k = 0; k < 40; k++) cycle(1'b0, 1'b1);

        // R3: pause enable on a cycle where the period-3 tick is high
        phase = "R3 pause while tick high";
        while (ticks[0] !== 1'b1) cycle(1'b0, 1'b1);
        for (int k = 0; k < 4; k++) cycle(1'b0, 1'b0);
        phase = "R3 resume";
        for (int k = 0; k < 15; k++) cycle(1'b0, 1'b1);

        // R3: short pauses scattered
        for (int k = 0; k < 30; k++) cycle(1'b0, (k % 4) != 1);

        // R4: reset wins over enable mid-count
        phase = "R4 reset mid-run";
        cycle(1'b1, 1'b1);
        cycle(1'b1, 1'b0);
        phase = "R1/R2 after reset";
        for (int k = 0; k < 26; k++) cycle(1'b0, 1'b1);

        // R5: period change mid-count applies after next wrap
        phase = "R5 period change";
        dyn_period = 8'd7;
        for (int k = 0; k < 30; k++) cycle(1'b0, 1'b1);
        while (dyn_tick !== 1'b1) cycle(1'b0, 1'b1);
        dyn_period = 8'd3;
        for (int k = 0; k < 20; k++) cycle(1'b0, 1'b1);

        // R6: period 0 and 1
        phase = "R6 period zero";
        dyn_period = 8'd0;
        for (int k = 0; k < 12; k++) cycle(1'b0, 1'b1);
        phase = "R6 period one";
        dyn_period = 8'd1;
        for (int k = 0; k < 12; k++) cycle(1'b0, 1'b1);
        phase = "R6 pause at period one";
        for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0);
        phase = "R5 back to two";
        dyn_period = 8'd2;
        for (int k = 0; k < 20; k++) cycle(1'b0, 1'b1);

        finish_run();
    end
endmodule